// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block gives a host controller read and write access to a bank of 128 eight-bit registers over a three-wire serial link. The link has a chip select, a serial clock and one data line that carries traffic in both directions. A separate active-low enable line gates the whole link. While that line is high, the slave ignores all bus activity. Inside the block, the data line is split into an input, an output and an output enable, so that a pad cell or a neighbouring driver can form the shared wire.

Each access is one frame of sixteen clock periods. The frame carries a direction bit, then a seven-bit register address, then eight data bits. On a write, the host drives all sixteen bits. On a read, the host drives only the first eight bits. The slave takes over the line after the eighth falling clock edge and shifts the register contents out.

All serial inputs are synchronised into the system clock domain with two flip-flops. Clock and chip-select edges are then detected on the synchronised copies. For this to work, the serial clock must run several times slower than the system clock.

Top module: `tw_reg_slave`

## Requirements
- R1: After reset, `sdio_oe` is low and every register reads back as 0x00.
- R2: A write frame stores its data at the addressed register. The frame is a 0 direction bit, then address bits 6 down to 0, then data bits 7 down to 0, each bit sampled on a rising serial clock edge. The store happens when chip select rises.
- R3: A read frame has a 1 as its direction bit. It returns the addressed register MSB first. Each new bit appears after a falling serial clock edge, so the host samples it on the next rising edge. A read leaves the register unchanged.
- R4: A write frame with fewer or more than exactly 16 rising clock edges before chip select rises is discarded.
- R5: While `if_en_n` is high, no frame is accepted: registers keep their values and `sdio_oe` stays low.
- R6: `sdio_oe` is low whenever `cs_n` or `if_en_n` is high, with no clock delay.
- R7: `sdio_oe` stays low for the whole of a write frame.
- R8: In a read frame, `sdio_oe` stays low until the falling edge of the eighth serial clock and is high from then on.
- R9: A frame starts only on a falling chip select while the enable line is low. Raising `if_en_n` mid-frame aborts the frame, and lowering it while chip select is already low starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_en_n | input | 1 | Interface enable, active low |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, idles low |
| sdio_i | input | 1 | Data line as seen at the pad |
| sdio_o | output | 1 | Data driven by the slave during reads |
| sdio_oe | output | 1 | Output enable for the data line |

## Verification
The assertions assume that the serial clock, chip select and data line change slowly compared with the system clock. Each serial clock level must be held for several system cycles, so the two-flop copies show every edge in order, and the data bit must settle before the rising edge that samples it. The stimulus holds every serial level for eight system cycles and changes data only in the clock-low phase. It also keeps half a serial period of margin around chip select, so no assertion sees an edge that the synchroniser could merge or reorder.

// File: rtl/tw_pkg.sv
package tw_pkg;
    localparam int TW_ADDR_W = 7;
    localparam int TW_DATA_W = 8;

    // bits in a complete frame: direction, address, data
    function automatic int frame_bits(input int aw, input int dw);
        return 1 + aw + dw;
    endfunction
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int            W   = 1,
    parameter logic [W-1:0]  RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_i,
    output logic [W-1:0] s_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST;
            sync_q <= RST;
        end else begin
            meta_q <= a_i;
            sync_q <= meta_q;
        end
    end

    assign s_o = sync_q;
endmodule

// File: rtl/tw_regfile.sv
module tw_regfile #(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/tw_frame.sv
module tw_frame #(
    parameter int AW = 7,
    parameter int DW = 8,
    parameter int FB = 1 + AW + DW,
    parameter int CW = $clog2(FB + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_n_s,
    input  logic          cs_n_s,
    input  logic          sclk_s,
    input  logic          din_s,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          oe_q,
    output logic          dout,
    output logic [CW-1:0] cnt_o
);
    localparam int             HDR      = 1 + AW;
    localparam logic [CW-1:0]  CNT_HDR  = CW'(HDR);
    localparam logic [CW-1:0]  CNT_FULL = CW'(FB);

    typedef struct packed {
        logic          live;
        logic          cs_prev;
        logic          sclk_prev;
        logic [CW-1:0] cnt;
        logic [FB-1:0] sh;
        logic          oe;
        logic [DW-1:0] obuf;
    } eng_t;

    eng_t st_d, st_q;
    logic rise, fall, wr_d;

    always_comb begin
        st_d           = st_q;
        wr_d           = 1'b0;
        st_d.sclk_prev = sclk_s;
        st_d.cs_prev   = cs_n_s;
        rise = sclk_s & ~st_q.sclk_prev;
        fall = ~sclk_s & st_q.sclk_prev;
        if (en_n_s || cs_n_s) begin
            // end of frame: commit only a complete write
            wr_d = st_q.live && !en_n_s && cs_n_s &&
                   (st_q.cnt == CNT_FULL) && !st_q.sh[FB-1];
            st_d.live = 1'b0;
            st_d.oe   = 1'b0;
        end else if (st_q.cs_prev && !st_q.live) begin
            st_d.live = 1'b1;
            st_d.cnt  = '0;
            st_d.sh   = '0;
            st_d.oe   = 1'b0;
        end else if (st_q.live) begin
            if (rise) begin
                if (st_q.cnt != '1) st_d.cnt = st_q.cnt + 1'b1;
                st_d.sh = {st_q.sh[FB-2:0], din_s};
            end else if (fall) begin
                if (st_q.cnt == CNT_HDR && st_q.sh[HDR-1]) begin
                    st_d.oe   = 1'b1;
                    st_d.obuf = rd_data;
                end else if (st_q.oe && st_q.cnt > CNT_HDR && st_q.cnt < CNT_FULL) begin
                    st_d.obuf = {st_q.obuf[DW-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.cs_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en   = wr_d;
    assign wr_addr = st_q.sh[FB-2 -: AW];
    assign wr_data = st_q.sh[DW-1:0];
    assign rd_addr = st_q.sh[AW-1:0];
    assign oe_q    = st_q.oe;
    assign dout    = st_q.obuf[DW-1];
    assign cnt_o   = st_q.cnt;
endmodule

// File: rtl/tw_reg_slave.sv
module tw_reg_slave #(
    parameter int ADDR_W = tw_pkg::TW_ADDR_W,
    parameter int DATA_W = tw_pkg::TW_DATA_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic if_en_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdio_i,
    output logic sdio_o,
    output logic sdio_oe
);
    localparam int FB   = tw_pkg::frame_bits(ADDR_W, DATA_W);
    localparam int CW   = $clog2(FB + 2);
    localparam int HDR  = 1 + ADDR_W;

    logic               en_n_s, cs_n_s, sclk_s, din_s;
    logic [ADDR_W-1:0]  rd_addr, wr_addr;
    logic [DATA_W-1:0]  rd_data, wr_data;
    logic               wr_en, oe_q, dout;
    logic [CW-1:0]      cnt;

    tw_sync #(.W(4), .RST(4'b1100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .a_i   ({if_en_n, cs_n, sclk, sdio_i}),
        .s_o   ({en_n_s, cs_n_s, sclk_s, din_s})
    );

    tw_frame #(.AW(ADDR_W), .DW(DATA_W), .FB(FB), .CW(CW)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_n_s  (en_n_s),
        .cs_n_s  (cs_n_s),
        .sclk_s  (sclk_s),
        .din_s   (din_s),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .oe_q    (oe_q),
        .dout    (dout),
        .cnt_o   (cnt)
    );

    tw_regfile #(.AW(ADDR_W), .DW(DATA_W)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    // release the line at once when chip select or the enable goes high
    assign sdio_oe = oe_q & ~cs_n & ~if_en_n;
    assign sdio_o  = dout;
endmodule

// File: rtl/tw_reg_slave_chk.sv
module tw_reg_slave_chk #(
    parameter int CW  = 5,
    parameter int FB  = 16,
    parameter int HDR = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          if_en_n,
    input logic          sdio_oe,
    input logic          sdio_o,
    input logic          en_n_s,
    input logic          sclk_s,
    input logic          oe_q,
    input logic          wr_en,
    input logic [CW-1:0] cnt
);
    p_oe_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sdio_oe |-> (!cs_n && !if_en_n));

    p_full_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (cnt == CW'(FB)));

    p_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !en_n_s);

    p_turn_at_eighth_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_q) |-> ($past(cnt) == CW'(HDR)));

    p_shift_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_q && $past(oe_q) && !$stable(sdio_o)) |-> ($past(sclk_s, 2) && !$past(sclk_s, 1)));

    p_no_drive_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !oe_q);
endmodule

bind tw_reg_slave tw_reg_slave_chk #(.CW(CW), .FB(FB), .HDR(HDR)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .if_en_n (if_en_n),
    .sdio_oe (sdio_oe),
    .sdio_o  (sdio_o),
    .en_n_s  (en_n_s),
    .sclk_s  (sclk_s),
    .oe_q    (oe_q),
    .wr_en   (wr_en),
    .cnt     (cnt)
);

// File: tb/tw_reg_slave_bench.sv
`timescale 1ns/1ps
module tw_reg_slave_bench;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic if_en_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic sdio_i = 1'b0;
    logic sdio_o, sdio_oe;

    always #2 clk = ~clk;

    tw_reg_slave u_tw_reg_slave (
        .clk     (clk),
        .rst_n   (rst_n),
        .if_en_n (if_en_n),
        .cs_n    (cs_n),
        .sclk    (sclk),
        .sdio_i  (sdio_i),
        .sdio_o  (sdio_o),
        .sdio_oe (sdio_oe)
    );

    int total = 0;
    int bad   = 0;

    // kind: 0 write, 1 read (val = expected), 2 write with enable held high
    typedef struct packed {
        logic [1:0] kind;
        logic [6:0] addr;
        logic [7:0] val;
        logic [4:0] nr;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{2'd0, 7'h05, 8'hA5, 5'd16},
        '{2'd1, 7'h05, 8'hA5, 5'd16},
        '{2'd0, 7'h7F, 8'h3C, 5'd16},
        '{2'd1, 7'h7F, 8'h3C, 5'd16},
        '{2'd0, 7'h05, 8'hFF, 5'd15},
        '{2'd1, 7'h05, 8'hA5, 5'd16},
        '{2'd0, 7'h05, 8'h11, 5'd17},
        '{2'd1, 7'h05, 8'hA5, 5'd16},
        '{2'd2, 7'h00, 8'h99, 5'd16},
        '{2'd1, 7'h00, 8'h00, 5'd16},
        '{2'd0, 7'h00, 8'h01, 5'd16},
        '{2'd1, 7'h00, 8'h01, 5'd16}
    };
    localparam string REQS [12] = '{"R2", "R2", "R2", "R3", "R4", "R4",
                                    "R4", "R4", "R5", "R5", "R2", "R3"};

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame(input bit rw, input logic [6:0] a, input logic [7:0] d, input int nr,
                         input bit en_hi, input int abort_at, input bit late_en,
                         output logic [7:0] rd, output bit oe_bad);
        logic [15:0] word;
        word   = {rw, a, d};
        rd     = '0;
        oe_bad = 1'b0;
        if (late_en) begin
            if_en_n = 1'b1;
            wait_n(4);
            cs_n = 1'b0;
            wait_n(HALF);
            if_en_n = 1'b0;
        end else begin
            if_en_n = en_hi;
            wait_n(4);
            cs_n = 1'b0;
        end
        wait_n(HALF);
        for (int i = 0; i < nr; i++) begin
            if (abort_at != 0 && i == abort_at) if_en_n = 1'b1;
            sdio_i = (i < 16 && !(rw && i >= 8)) ? word[15-i] : 1'b0;
            wait_n(HALF);
            if (rw && !en_hi && !late_en && i >= 8) begin
                if (!sdio_oe) oe_bad = 1'b1;
                if (i < 16) rd[15-i] = sdio_o;
            end else if (sdio_oe) begin
                oe_bad = 1'b1;
            end
            sclk = 1'b1;
            wait_n(HALF);
            sclk = 1'b0;
        end
        wait_n(HALF);
        cs_n = 1'b1;
        wait_n(1);
        chk(sdio_oe == 1'b0, "R6", {31'd0, sdio_oe}, 32'd0);
        wait_n(HALF);
        if_en_n = 1'b0;
        wait_n(4);
    endtask

    task automatic rd_check(input logic [6:0] a, input logic [7:0] exp, input string req);
        logic [7:0] v;
        bit ob;
        frame(1'b1, a, 8'h00, 16, 1'b0, 0, 1'b0, v, ob);
        chk(v == exp, req, {24'd0, v}, {24'd0, exp});
        chk(!ob, "R8", {31'd0, ob}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        bit ob;
        wait_n(5);
        rst_n = 1'b1;
        wait_n(3);
        // R1: reset state
        chk(sdio_oe == 1'b0, "R1", {31'd0, sdio_oe}, 32'd0);
        rd_check(7'h33, 8'h00, "R1");

        foreach (VECS[k]) begin
            case (VECS[k].kind)
                2'd1: rd_check(VECS[k].addr, VECS[k].val, REQS[k]);
                default: begin
                    frame(1'b0, VECS[k].addr, VECS[k].val, int'(VECS[k].nr),
                          VECS[k].kind == 2'd2, 0, 1'b0, v, ob);
                    chk(!ob, (VECS[k].kind == 2'd2) ? "R5" : "R7", {31'd0, ob}, 32'd0);
                end
            endcase
        end

        // R9: enable raised mid-frame aborts the write
        frame(1'b0, 7'h7F, 8'h00, 16, 1'b0, 10, 1'b0, v, ob);
        rd_check(7'h7F, 8'h3C, "R9");
        // R9: enable lowered after chip select already low starts no frame
        frame(1'b0, 7'h7F, 8'h55, 16, 1'b0, 0, 1'b1, v, ob);
        chk(!ob, "R9", {31'd0, ob}, 32'd0);
        rd_check(7'h7F, 8'h3C, "R9");
        // R3: repeated read returns the same value
        rd_check(7'h7F, 8'h3C, "R3");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule